// File: doc/BRIEF.md
# Streaming Program-and-Verify Sequencer for a One-Time-Programmable Word Array

This block drives a two-pass write of a run of words into a one-time-programmable (OTP) array. A host unlocks it with a three-write key sequence. It then streams words: the first write carries a start address, and every later write carries only a tag. The tag is the three address bits 19:17. A tag equal to the start's tag means "next word", and the block advances its own word pointer. A different tag ends the pass. The host then streams the same words a second time. Each word is compared with what the array holds. A mismatch is reprogrammed a bounded number of times, and the run fails if the word still differs.

The host paces the stream by polling a status word. Bit 0 is the ready bit, and a word may be written only while it reads 0. A write sent while it is 1 is dropped. This polling handshake takes the place of a valid/ready pair. The array is a small register file reset to all ones, and writing a word only clears bits. While a run is active or has failed, every read returns the status word instead of array data. A failure holds until the host writes the abort byte.

Top module: `mwp_sequencer`

## Requirements
- R1: After reset the block is in read mode, every word reads 16'hFFFF, and rd_data shows the word selected by the low IDX_W bits of rd_addr, with no clock delay.
- R2: A run starts after three accepted writes, compared on wr_addr[10:0] and wr_data[7:0]: 8'hAA at 11'h555, then 8'h55 at 11'h2AA, then 8'h20 at 11'h555. Any other write after the first key returns the block to read mode.
- R3: In the program pass, the first write stores its word at the index given by wr_addr[IDX_W-1:0]. A later write whose bits 19:17 equal those of the start address stores the next word at the previous index plus one, wrapping at WORDS. Its bits 16:0 are ignored.
- R4: A write whose bits 19:17 differ from the start's ends the current pass, and its data is ignored. After the program pass this opens a verify pass with the same structure. After an error-free verify pass it returns the block to read mode.
- R5: Programming a word only clears bits: the stored value becomes the old value AND the written word.
- R6: Status bit 0 is 0 only while a word can be taken. It is 1 for LAUNCH_CYC cycles after the key sequence, for PROG_CYC cycles per word programmed, during a verify compare, and after a failure. Writes that arrive while it is 1 are ignored.
- R7: A verify word that differs from the stored value is reprogrammed, up to MAX_RETRY times. If it still differs, the pass stops and status bit 5 (error) is set. The error stays set until the abort write.
- R8: If vpp_ok falls while a run is active, the run aborts on the next edge, status bits 5 and 4 (supply error) are set, and the word being programmed is not written.
- R9: While a run is active or failed, reads return the status word. Bit 6 inverts after each rd_en strobe, and bits 15:7 and 3:1 read 0.
- R10: A write with wr_data[7:0]=8'hF0 at any address, made while failed and with vpp_ok high, returns the block to read mode and clears both flags. During a pass the same byte is an ordinary data word.
- R11: A verify mismatch that clearing bits can repair passes after a reprogram, and the stored word then equals the verify word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vpp_ok | input | 1 | Program supply within range; writes are ignored while low |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address (key address, start address or tag) |
| wr_data | input | DATA_W | Write data (key byte or data word) |
| rd_en | input | 1 | Host read strobe; advances the toggle bit |
| rd_addr | input | ADDR_W | Read address; low IDX_W bits select a word |
| rd_data | output | DATA_W | Array word in read mode, status word otherwise |

## Verification
Assertions check on every cycle that stored bits never rise, that writes made while not ready leave the word pointer alone, that a supply drop during a run raises both flags at once, that the error flag holds until an abort write, and that the status word keeps its zero bits and inverts bit 6 after each read strobe. Other properties depend on the data and need the bench's scenarios: which index a continue write lands on, where a stream wraps, whether a reprogram repairs a word or declares failure, that a dropped write really changes no word, and that an abort byte sent mid-pass is stored as data. The bench models the array and predicts the outcome of every run from that model.

// File: rtl/mwp_pkg.sv
`timescale 1ns/1ps
package mwp_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_KEY1, ST_KEY2, ST_LAUNCH, ST_ACCEPT, ST_BURN, ST_CHECK, ST_FAIL
  } mwp_state_e;

  typedef enum logic {PH_PROGRAM, PH_VERIFY} mwp_phase_e;

  localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
  localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;
  localparam logic [7:0]  KEY_FIRST     = 8'hAA;
  localparam logic [7:0]  KEY_SECOND    = 8'h55;
  localparam logic [7:0]  KEY_STREAM    = 8'h20;
  localparam logic [7:0]  KEY_ABORT     = 8'hF0;

  localparam int SB_READY  = 0;
  localparam int SB_SUPPLY = 4;
  localparam int SB_ERROR  = 5;
  localparam int SB_TOGGLE = 6;
endpackage

// File: rtl/mwp_cmd_match.sv
`timescale 1ns/1ps
// Recognises the unlock keys and the abort byte on one write beat.
module mwp_cmd_match
  import mwp_pkg::*;
(
  input  logic [10:0] cmd_addr,
  input  logic [7:0]  cmd_byte,
  output logic        hit_first,
  output logic        hit_second,
  output logic        hit_stream,
  output logic        hit_abort
);
  assign hit_first  = (cmd_addr == UNLOCK_ADDR_A) && (cmd_byte == KEY_FIRST);
  assign hit_second = (cmd_addr == UNLOCK_ADDR_B) && (cmd_byte == KEY_SECOND);
  assign hit_stream = (cmd_addr == UNLOCK_ADDR_A) && (cmd_byte == KEY_STREAM);
  assign hit_abort  = (cmd_byte == KEY_ABORT);
endmodule

// File: rtl/mwp_busy_timer.sv
`timescale 1ns/1ps
// Down-counter: after load with N, done is high in the N-th cycle.
module mwp_busy_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/mwp_otp_array.sv
`timescale 1ns/1ps
// Word array that resets to all ones; a write can only clear bits.
module mwp_otp_array #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [IDX_W-1:0]        ridx_a,
  output logic [DATA_W-1:0]       rdata_a,
  input  logic [IDX_W-1:0]        ridx_b,
  output logic [DATA_W-1:0]       rdata_b,
  output logic [WORDS*DATA_W-1:0] mem_flat
);
  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cell_q <= '1;
      else if (we && widx == IDX_W'(w))    cell_q <= cell_q & wdata;
    end
    assign words[w] = cell_q;
    assign mem_flat[w*DATA_W +: DATA_W] = cell_q;
  end

  assign rdata_a = words[ridx_a];
  assign rdata_b = words[ridx_b];
endmodule

// File: rtl/mwp_sequencer.sv
`timescale 1ns/1ps
module mwp_sequencer
  import mwp_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int WORDS      = 16,
  parameter int TAG_LSB    = 17,
  parameter int PROG_CYC   = 6,
  parameter int LAUNCH_CYC = 3,
  parameter int MAX_RETRY  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W   = $clog2(WORDS);
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int LONGEST = (PROG_CYC > LAUNCH_CYC) ? PROG_CYC : LAUNCH_CYC;
  localparam int TIME_W  = $clog2(LONGEST + 1);
  localparam int RTRY_W  = $clog2(MAX_RETRY + 1);

  mwp_state_e         state_q, state_d;
  mwp_phase_e         phase_q, phase_d;
  logic               first_q, first_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic [DATA_W-1:0]  word_q, word_d;
  logic [RTRY_W-1:0]  tries_q, tries_d;
  logic               err_q, err_d, verr_q, verr_d, tog_q;

  logic hit_first, hit_second, hit_stream, hit_abort;
  logic tmr_load, tmr_done, arr_we;
  logic [TIME_W-1:0] tmr_val;
  logic [DATA_W-1:0] arr_rd, stored;
  logic [WORDS*DATA_W-1:0] mem_flat;

  logic take, in_op, show_status, accepting, tag_hit;
  logic unused_addr_bits;

  assign unused_addr_bits = ^{wr_addr, rd_addr};

  mwp_cmd_match u_match (
    .cmd_addr  (wr_addr[10:0]),
    .cmd_byte  (wr_data[7:0]),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .hit_stream(hit_stream),
    .hit_abort (hit_abort)
  );

  mwp_busy_timer #(.CNT_W(TIME_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  mwp_otp_array #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (arr_we),
    .widx    (ptr_q),
    .wdata   (word_q),
    .ridx_a  (rd_addr[IDX_W-1:0]),
    .rdata_a (arr_rd),
    .ridx_b  (ptr_q),
    .rdata_b (stored),
    .mem_flat(mem_flat)
  );

  assign take        = wr_en && vpp_ok;
  assign in_op       = (state_q == ST_LAUNCH) || (state_q == ST_ACCEPT) ||
                       (state_q == ST_BURN)   || (state_q == ST_CHECK);
  assign show_status = in_op || (state_q == ST_FAIL);
  assign accepting   = (state_q == ST_ACCEPT);
  assign tag_hit     = (wr_addr[ADDR_W-1:TAG_LSB] == tag_q);

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    first_d  = first_q;
    tag_d    = tag_q;
    ptr_d    = ptr_q;
    word_d   = word_q;
    tries_d  = tries_q;
    err_d    = err_q;
    verr_d   = verr_q;
    tmr_load = 1'b0;
    tmr_val  = TIME_W'(PROG_CYC);
    arr_we   = 1'b0;
    if (in_op && !vpp_ok) begin
      state_d = ST_FAIL;
      err_d   = 1'b1;
      verr_d  = 1'b1;
    end else begin
      case (state_q)
        ST_READ:  if (take && hit_first) state_d = ST_KEY1;
        ST_KEY1:  if (take) state_d = hit_second ? ST_KEY2 : ST_READ;
        ST_KEY2: begin
          if (take) begin
            if (hit_stream) begin
              state_d  = ST_LAUNCH;
              phase_d  = PH_PROGRAM;
              first_d  = 1'b1;
              tmr_load = 1'b1;
              tmr_val  = TIME_W'(LAUNCH_CYC);
            end else begin
              state_d = ST_READ;
            end
          end
        end
        ST_LAUNCH: if (tmr_done) state_d = ST_ACCEPT;
        ST_ACCEPT: begin
          if (take) begin
            if (first_q || tag_hit) begin
              if (first_q) begin
                tag_d = wr_addr[ADDR_W-1:TAG_LSB];
                ptr_d = wr_addr[IDX_W-1:0];
              end else begin
                ptr_d = ptr_q + IDX_W'(1);
              end
              first_d = 1'b0;
              word_d  = wr_data;
              tries_d = '0;
              if (phase_q == PH_PROGRAM) begin
                state_d  = ST_BURN;
                tmr_load = 1'b1;
              end else begin
                state_d = ST_CHECK;
              end
            end else if (phase_q == PH_PROGRAM) begin
              phase_d = PH_VERIFY;
              first_d = 1'b1;
            end else begin
              state_d = ST_READ;
            end
          end
        end
        ST_BURN: begin
          if (tmr_done) begin
            arr_we  = 1'b1;
            state_d = (phase_q == PH_VERIFY) ? ST_CHECK : ST_ACCEPT;
          end
        end
        ST_CHECK: begin
          if (stored == word_q) begin
            state_d = ST_ACCEPT;
          end else if (tries_q < RTRY_W'(MAX_RETRY)) begin
            tries_d  = tries_q + RTRY_W'(1);
            state_d  = ST_BURN;
            tmr_load = 1'b1;
          end else begin
            state_d = ST_FAIL;
            err_d   = 1'b1;
          end
        end
        ST_FAIL: begin
          if (take && hit_abort) begin
            state_d = ST_READ;
            err_d   = 1'b0;
            verr_d  = 1'b0;
          end
        end
        default: state_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      phase_q <= PH_PROGRAM;
      first_q <= 1'b1;
      tag_q   <= '0;
      ptr_q   <= '0;
      word_q  <= '0;
      tries_q <= '0;
      err_q   <= 1'b0;
      verr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      first_q <= first_d;
      tag_q   <= tag_d;
      ptr_q   <= ptr_d;
      word_q  <= word_d;
      tries_q <= tries_d;
      err_q   <= err_d;
      verr_q  <= verr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tog_q <= 1'b0;
    else if (!show_status) tog_q <= 1'b0;
    else if (rd_en)        tog_q <= ~tog_q;
  end

  always_comb begin
    if (show_status) begin
      rd_data            = '0;
      rd_data[SB_READY]  = ~accepting;
      rd_data[SB_SUPPLY] = verr_q;
      rd_data[SB_ERROR]  = err_q;
      rd_data[SB_TOGGLE] = tog_q;
    end else begin
      rd_data = arr_rd;
    end
  end
endmodule

// File: rtl/mwp_sequencer_chk.sv
`timescale 1ns/1ps
module mwp_sequencer_chk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int MEM_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vpp_ok,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              in_op,
  input logic              show_status,
  input logic              accepting,
  input logic              err_q,
  input logic              verr_q,
  input logic [IDX_W-1:0]  ptr_q,
  input logic [MEM_W-1:0]  mem_flat
);
  logic unused_chk;
  assign unused_chk = ^wr_data[DATA_W-1:8];

  AST_BITS_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_flat & ~$past(mem_flat)) == '0)); // R5

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!accepting && wr_en) |=> $stable(ptr_q)); // R6

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_en && vpp_ok && wr_data[7:0] == 8'hF0)) |=> err_q); // R7

  AST_SUPPLY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_op && !vpp_ok) |=> (err_q && verr_q && !accepting)); // R8

  AST_STATUS_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    show_status |-> (rd_data[3:1] == '0 && rd_data[DATA_W-1:7] == '0)); // R9

  AST_TOGGLE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (show_status && rd_en) |=> (!show_status || rd_data[6] != $past(rd_data[6]))); // R9
endmodule

bind mwp_sequencer mwp_sequencer_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .MEM_W(WORDS*DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vpp_ok     (vpp_ok),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .in_op      (in_op),
  .show_status(show_status),
  .accepting  (accepting),
  .err_q      (err_q),
  .verr_q     (verr_q),
  .ptr_q      (ptr_q),
  .mem_flat   (mem_flat)
);

// File: tb/tb_mwp_sequencer.sv
`timescale 1ns/1ps
module tb_mwp_sequencer;
  localparam int NW = 16;

  logic        clk = 1'b0, rst_n = 1'b0, vpp_ok = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [19:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] model [NW];
  logic [15:0] pdat  [NW];
  logic [15:0] vdat  [NW];

  always #2 clk = ~clk;

  mwp_sequencer dut (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_addr(input logic [2:0] tag, input logic [16:0] low);
    return {tag, low};
  endfunction

  task automatic bus_write(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_ready(output logic [15:0] st);
    logic [15:0] s;
    s = 16'h0001;
    for (int i = 0; i < 200; i++) begin
      bus_read(20'h0, s);
      if (!s[0] || s[5]) break;
    end
    st = s;
    if (s[0] && !s[5]) begin
      n_tests++; n_fail++;
      $display("FAIL R6 ready bit stuck actual=%h expected=ready", s);
    end
  endtask

  task automatic unlock();
    bus_write(20'h00555, 16'h00AA);
    bus_write(20'h002AA, 16'h0055);
    bus_write(20'h00555, 16'h0020);
  endtask

  task automatic check_array(input string req);
    logic [15:0] v;
    for (int i = 0; i < NW; i++) begin
      bus_read({16'($urandom), 4'(i)}, v);
      check(req, v, model[i]);
    end
  endtask

  // Full two-pass run with pdat/vdat; outcome predicted from the model.
  task automatic do_stream(input int start, input int n, input logic [2:0] tag);
    logic [15:0] s, s1, s2;
    logic [16:0] lo;
    int idx, fail_at;
    fail_at = -1;
    unlock();
    bus_read(20'h0, s);
    check("R6 ready bit high during launch", 16'(s[0]), 16'h1);
    wait_ready(s);
    check("R2 unlock opens stream", 16'(s[0]), 16'h0);
    for (int k = 0; k < n; k++) begin
      if (k > 0) wait_ready(s);
      lo = 17'($urandom);
      if (k == 0) lo[3:0] = 4'(start);
      bus_write(mk_addr(tag, lo), pdat[k]);
      idx = (start + k) % NW;
      model[idx] = model[idx] & pdat[k];
    end
    wait_ready(s);
    bus_write(mk_addr(tag ^ 3'b100, 17'($urandom)), 16'($urandom));
    for (int k = 0; k < n; k++) begin
      wait_ready(s);
      lo = 17'($urandom);
      if (k == 0) lo[3:0] = 4'(start);
      bus_write(mk_addr(tag, lo), vdat[k]);
      idx = (start + k) % NW;
      if (model[idx] != vdat[k]) begin
        model[idx] = model[idx] & vdat[k];
        if (model[idx] != vdat[k]) begin
          fail_at = k;
          break;
        end
      end
    end
    wait_ready(s);
    if (fail_at >= 0) begin
      check("R7 error bit after failed reprogram", 16'(s[5]), 16'h1);
      check("R7 ready bit high when failed", 16'(s[0]), 16'h1);
      check("R8 supply bit clear on data failure", 16'(s[4]), 16'h0);
      bus_write(20'h00555, 16'h00AA);
      bus_read(20'h0, s1);
      bus_read(20'h0, s2);
      check("R7 failure holds against other writes", 16'(s1[5]), 16'h1);
      check("R9 toggle bit inverts per read", 16'(s1[6] ^ s2[6]), 16'h1);
      bus_write(20'($urandom), 16'hFFF0);
    end else begin
      check("R7 no error on good verify", 16'(s[5]), 16'h0);
      bus_write(mk_addr(tag ^ 3'b001, 17'($urandom)), 16'($urandom));
    end
    check_array("R4 R5 array after run");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s, v, hole;
    int start, n, mode, idx;
    logic [2:0] tag;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_array("R1 erased after reset");

    // R2 broken unlock returns to read mode
    bus_write(20'h00555, 16'h00AA);
    bus_write(20'h002AA, 16'h0012);
    bus_write(20'h00555, 16'h0020);
    bus_read(20'h3, v);
    check("R2 bad key leaves read mode", v, 16'hFFFF);

    // R3 R4 R10: stream with abort byte as data
    pdat[0] = 16'h00F0; pdat[1] = 16'hA5A5; pdat[2] = 16'h1234;
    for (int k = 0; k < 3; k++) vdat[k] = pdat[k];
    do_stream(12, 3, 3'd5);
    check("R10 abort byte stored as data", model[12], 16'h00F0);

    // R3 wrap from last index to 0
    pdat[0] = 16'h0F0F; pdat[1] = 16'h5555;
    vdat[0] = 16'h0F0F; vdat[1] = 16'h5555;
    do_stream(15, 2, 3'd0);

    // R7 unrepairable word (0 to 1)
    pdat[0] = 16'h0F0F; pdat[1] = 16'h3C3C;
    vdat[0] = 16'h0F0F; vdat[1] = 16'h3D3C;
    do_stream(5, 2, 3'd7);
    check("R7 model shows failure kept zeros", model[6], 16'h3C3C);

    // R11 repairable mismatch
    pdat[0] = 16'h7777; vdat[0] = 16'h3333;
    do_stream(7, 1, 3'd2);
    bus_read(20'h7, v);
    check("R11 reprogram repairs word", v, 16'h3333);

    // R6 write during programming is dropped
    unlock();
    wait_ready(s);
    bus_write(mk_addr(3'd2, 17'h00009), 16'hC3C3);
    bus_read(20'h0, s);
    check("R6 ready bit high while programming", 16'(s[0]), 16'h1);
    bus_write(mk_addr(3'd2, 17'h1FFF0), 16'h0000);
    wait_ready(s);
    bus_write(mk_addr(3'd2, 17'h0ABC0), 16'h8181);
    wait_ready(s);
    bus_write(mk_addr(3'd3, 17'h0), 16'h0);
    wait_ready(s);
    bus_write(mk_addr(3'd2, 17'h00009), 16'hC3C3);
    wait_ready(s);
    bus_write(mk_addr(3'd2, 17'h12340), 16'h8181);
    wait_ready(s);
    bus_write(mk_addr(3'd6, 17'h0), 16'h0);
    model[9] = 16'hC3C3; model[10] = 16'h8181;
    check_array("R6 dropped write changed nothing");

    // R8 supply drop during programming
    unlock();
    wait_ready(s);
    bus_write(mk_addr(3'd1, 17'h00008), 16'h0000);
    @(negedge clk);
    vpp_ok = 1'b0;
    @(negedge clk);
    bus_read(20'h0, s);
    check("R8 error bit on supply drop", 16'(s[5]), 16'h1);
    check("R8 supply bit on supply drop", 16'(s[4]), 16'h1);
    vpp_ok = 1'b1;
    bus_write(20'h1234, 16'h00F0);
    bus_read(20'h8, v);
    check("R8 R10 aborted word untouched, read mode back", v, 16'hFFFF);

    // Random runs
    for (int r = 0; r < 8; r++) begin
      start = $urandom_range(0, NW - 1);
      n     = $urandom_range(1, 5);
      tag   = 3'($urandom);
      for (int k = 0; k < n; k++) begin
        idx = (start + k) % NW;
        pdat[k] = model[idx] & 16'($urandom | 32'h0000_8421);
        mode = $urandom_range(0, 2);
        hole = ~pdat[k];
        if (mode == 0)      vdat[k] = pdat[k];
        else if (mode == 1) vdat[k] = pdat[k] & 16'($urandom);
        else                vdat[k] = (hole != 0) ? (pdat[k] | (hole & (~hole + 16'h1))) : pdat[k];
      end
      do_stream(start, n, tag);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule